// File: doc/BRIEF.md
# Cache Controller Interrupt Aggregator

This block is the interrupt register bank of a level-2 cache controller. Nine single-cycle event inputs arrive from elsewhere in the controller: event-counter activity, tag and data RAM read and write errors, tag and data RAM read parity errors, and slave and decode error responses from the downstream memory port. Each event is latched into a sticky raw status bit. A mask register gates the raw bits into masked status. Every masked bit drives its own interrupt line, and one combined line is the OR of all masked bits.

Software reaches the bank through a simple register port. It writes the mask, reads the raw and masked views, and writes ones to a clear register to acknowledge events. A decode-error response is reported as a slave error, so the decode-error status bit never sets and its line stays low. Reads return data one cycle after the read strobe, together with a valid pulse.

Top module: `intr_aggr`

## Requirements
- R1: After a synchronous active-low reset, raw status and mask are all zero, every interrupt line is low and regRdValid is low.
- R2: A one-cycle pulse on a source input sets its raw status bit on that clock edge, and the bit stays set with no further pulse. Bit positions: 0 event counter, 1 tag parity, 2 data parity, 3 tag read error, 4 data read error, 5 tag write error, 6 data write error, 7 slave error, 8 decode error.
- R3: A decode-error pulse sets raw bit 7 (slave error). Raw bit 8 always reads zero, and decErrIrq stays low.
- R4: Writing to offset 0x220 clears each raw bit whose data bit is 1 and leaves the others unchanged.
- R5: When a source pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: Masked status (offset 0x218) equals raw status AND mask, and each per-source interrupt line equals its masked status bit.
- R7: combIrq is high exactly when any masked status bit is set.
- R8: The mask at offset 0x214 is read/write over bits 8..0 and resets to zero. Bits 31..9 read as zero.
- R9: A read of the clear offset 0x220, or of any unmapped offset, returns zero.
- R10: Writes to the masked status offset 0x218 and the raw status offset 0x21C change no state.
- R11: Read data for a regRd strobe appears on regRdata in the following cycle, with regRdValid high for exactly that cycle. Raw status sits at offset 0x21C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| evtCntPulse | input | 1 | Event counter overflow or increment pulse |
| tagParPulse | input | 1 | Tag RAM read parity error pulse |
| dataParPulse | input | 1 | Data RAM read parity error pulse |
| tagRdErrPulse | input | 1 | Tag RAM read error pulse |
| dataRdErrPulse | input | 1 | Data RAM read error pulse |
| tagWrErrPulse | input | 1 | Tag RAM write error pulse |
| dataWrErrPulse | input | 1 | Data RAM write error pulse |
| slvErrPulse | input | 1 | Downstream slave error pulse |
| decErrPulse | input | 1 | Downstream decode error pulse |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data |
| regRdValid | output | 1 | Read data valid |
| evtCntIrq | output | 1 | Event counter interrupt |
| tagParIrq | output | 1 | Tag parity interrupt |
| dataParIrq | output | 1 | Data parity interrupt |
| tagRdErrIrq | output | 1 | Tag read error interrupt |
| dataRdErrIrq | output | 1 | Data read error interrupt |
| tagWrErrIrq | output | 1 | Tag write error interrupt |
| dataWrErrIrq | output | 1 | Data write error interrupt |
| slvErrIrq | output | 1 | Slave error interrupt |
| decErrIrq | output | 1 | Decode error interrupt |
| combIrq | output | 1 | Combined interrupt |

## Verification
The bench targets the collision between a pulse and a clear of the same bit. A design that lets the clear win would lose an event and read back zero. It also drives a decode-error pulse into a clean bank. A design that does not fold it would show bit 8 set, or bit 7 clear, and would raise the wrong line. A partial clear with a mixed data pattern catches a clear that wipes the whole register. Writes of all ones to the two status views catch a decoder that aliases them onto the mask or the clear. Mask patterns that cover only some of the pending bits show whether combIrq follows the masked bits or the raw bits.

// File: rtl/intr_aggr_pkg.sv
package intr_aggr_pkg;
  localparam int SRC_N      = 9;
  localparam int B_EVT      = 0;
  localparam int B_TAG_PAR  = 1;
  localparam int B_DATA_PAR = 2;
  localparam int B_TAG_RD   = 3;
  localparam int B_DATA_RD  = 4;
  localparam int B_TAG_WR   = 5;
  localparam int B_DATA_WR  = 6;
  localparam int B_SLV      = 7;
  localparam int B_DEC      = 8;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_MASK   = 2'd1,
    RD_MASKED = 2'd2,
    RD_RAW    = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrClear;
    logic   rdEn;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/intr_aggr_ctrl.sv
module intr_aggr_ctrl
  import intr_aggr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int MASK_OFF   = 'h214,
  parameter int MASKED_OFF = 'h218,
  parameter int RAW_OFF    = 'h21C,
  parameter int CLR_OFF    = 'h220
) (
  input  logic              regRd,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(MASK_OFF);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(MASKED_OFF);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(RAW_OFF);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(CLR_OFF);

  logic hitMask, hitMasked, hitRaw, hitClr;

  always_comb begin
    hitMask   = (regAddr == A_MASK);
    hitMasked = (regAddr == A_MASKED);
    hitRaw    = (regAddr == A_RAW);
    hitClr    = (regAddr == A_CLR);
  end

  // Status views are read-only, the clear register is write-only.
  always_comb begin
    strb.wrMask  = regWr & hitMask;
    strb.wrClear = regWr & hitClr;
    strb.rdEn    = regRd;
    if (hitMask)        strb.rdSel = RD_MASK;
    else if (hitMasked) strb.rdSel = RD_MASKED;
    else if (hitRaw)    strb.rdSel = RD_RAW;
    else                strb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/intr_aggr_dp.sv
module intr_aggr_dp
  import intr_aggr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  srcVec,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] regWdata,
  output logic [SRC_N-1:0]  rawStat,
  output logic [SRC_N-1:0]  maskQ,
  output logic [SRC_N-1:0]  maskedStat,
  output logic [DATA_W-1:0] regRdata,
  output logic              regRdValid
);
  logic [SRC_N-1:0] setVec;
  logic [SRC_N-1:0] clrVec;
  logic             unusedWdata;

  assign clrVec      = strb.wrClear ? regWdata[SRC_N-1:0] : '0;
  assign unusedWdata = ^regWdata[DATA_W-1:SRC_N];

  // Decode errors fold into the slave-error bit; their own bit never sets.
  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    if (i == B_DEC) begin : g_dec
      assign setVec[i]  = 1'b0;
      assign rawStat[i] = 1'b0;
    end else begin : g_src
      if (i == B_SLV) begin : g_slv
        assign setVec[i] = srcVec[B_SLV] | srcVec[B_DEC];
      end else begin : g_plain
        assign setVec[i] = srcVec[i];
      end
      logic rawQ;
      always_ff @(posedge clk) begin
        if (!rstN)          rawQ <= 1'b0;
        else if (setVec[i]) rawQ <= 1'b1;
        else if (clrVec[i]) rawQ <= 1'b0;
      end
      assign rawStat[i] = rawQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.wrMask) maskQ <= regWdata[SRC_N-1:0];
  end

  assign maskedStat = rawStat & maskQ;

  logic [SRC_N-1:0] rdSelVal;
  always_comb begin
    unique case (strb.rdSel)
      RD_MASK:   rdSelVal = maskQ;
      RD_MASKED: rdSelVal = maskedStat;
      RD_RAW:    rdSelVal = rawStat;
      default:   rdSelVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata   <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= strb.rdEn;
      if (strb.rdEn) regRdata <= DATA_W'(rdSelVal);
    end
  end
endmodule

// File: rtl/intr_aggr.sv
module intr_aggr
  import intr_aggr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtCntPulse,
  input  logic              tagParPulse,
  input  logic              dataParPulse,
  input  logic              tagRdErrPulse,
  input  logic              dataRdErrPulse,
  input  logic              tagWrErrPulse,
  input  logic              dataWrErrPulse,
  input  logic              slvErrPulse,
  input  logic              decErrPulse,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regRdValid,
  output logic              evtCntIrq,
  output logic              tagParIrq,
  output logic              dataParIrq,
  output logic              tagRdErrIrq,
  output logic              dataRdErrIrq,
  output logic              tagWrErrIrq,
  output logic              dataWrErrIrq,
  output logic              slvErrIrq,
  output logic              decErrIrq,
  output logic              combIrq
);
  regStrobe_t       strb;
  logic [SRC_N-1:0] srcVec;
  logic [SRC_N-1:0] rawStat;
  logic [SRC_N-1:0] maskQ;
  logic [SRC_N-1:0] irqVec;

  assign srcVec = {decErrPulse, slvErrPulse, dataWrErrPulse, tagWrErrPulse,
                   dataRdErrPulse, tagRdErrPulse, dataParPulse, tagParPulse,
                   evtCntPulse};

  intr_aggr_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regRd   (regRd),
    .regWr   (regWr),
    .regAddr (regAddr),
    .strb    (strb)
  );

  intr_aggr_dp #(.DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .srcVec     (srcVec),
    .strb       (strb),
    .regWdata   (regWdata),
    .rawStat    (rawStat),
    .maskQ      (maskQ),
    .maskedStat (irqVec),
    .regRdata   (regRdata),
    .regRdValid (regRdValid)
  );

  assign evtCntIrq    = irqVec[B_EVT];
  assign tagParIrq    = irqVec[B_TAG_PAR];
  assign dataParIrq   = irqVec[B_DATA_PAR];
  assign tagRdErrIrq  = irqVec[B_TAG_RD];
  assign dataRdErrIrq = irqVec[B_DATA_RD];
  assign tagWrErrIrq  = irqVec[B_TAG_WR];
  assign dataWrErrIrq = irqVec[B_DATA_WR];
  assign slvErrIrq    = irqVec[B_SLV];
  assign decErrIrq    = irqVec[B_DEC];
  assign combIrq      = |irqVec;
endmodule

// File: rtl/intr_aggr_chk.sv
module intr_aggr_chk #(
  parameter int ADDR_W  = 12,
  parameter int SRC_N   = 9,
  parameter int CLR_OFF = 'h220
) (
  input logic              clk,
  input logic              rstN,
  input logic [SRC_N-1:0]  srcVec,
  input logic [SRC_N-1:0]  rawStat,
  input logic [SRC_N-1:0]  maskQ,
  input logic              regRd,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regRdValid,
  input logic [8:0]        lineVec,
  input logic              combIrq
);
  logic clrHit;
  assign clrHit = regWr && (regAddr == ADDR_W'(CLR_OFF));

  // R1
  reset_clean_chk: assert property (@(posedge clk)
    !rstN |=> (rawStat == '0 && maskQ == '0 && !regRdValid));

  // R2
  src_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|srcVec[SRC_N-2:0]) |=>
      ((rawStat[SRC_N-2:0] & $past(srcVec[SRC_N-2:0])) == $past(srcVec[SRC_N-2:0])));

  // R3
  dec_folds_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcVec[SRC_N-1] |=> rawStat[SRC_N-2]);

  // R3
  dec_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rawStat[SRC_N-1] && !lineVec[8]);

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrHit |=> ((rawStat & $past(rawStat)) == $past(rawStat)));

  // R6
  line_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineVec == (rawStat & maskQ));

  // R7
  comb_or_chk: assert property (@(posedge clk) disable iff (!rstN)
    combIrq == (|lineVec));

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> regRdValid);

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> !regRdValid);
endmodule

bind intr_aggr intr_aggr_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .srcVec     (srcVec),
  .rawStat    (rawStat),
  .maskQ      (maskQ),
  .regRd      (regRd),
  .regWr      (regWr),
  .regAddr    (regAddr),
  .regRdValid (regRdValid),
  .lineVec    ({decErrIrq, slvErrIrq, dataWrErrIrq, tagWrErrIrq, dataRdErrIrq,
                tagRdErrIrq, dataParIrq, tagParIrq, evtCntIrq}),
  .combIrq    (combIrq)
);

// File: tb/sim_intr_aggr.sv
`timescale 1ns/1ps
module sim_intr_aggr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  src = '0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regRdValid;
  logic [8:0]  lines;
  logic        combIrq;

  int vecCnt = 0;
  int badCnt = 0;
  logic [8:0] expRaw = '0;
  logic [8:0] expMask = '0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  intr_aggr u0 (
    .clk(clk), .rstN(rstN),
    .evtCntPulse(src[0]), .tagParPulse(src[1]), .dataParPulse(src[2]),
    .tagRdErrPulse(src[3]), .dataRdErrPulse(src[4]), .tagWrErrPulse(src[5]),
    .dataWrErrPulse(src[6]), .slvErrPulse(src[7]), .decErrPulse(src[8]),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .regRdValid(regRdValid),
    .evtCntIrq(lines[0]), .tagParIrq(lines[1]), .dataParIrq(lines[2]),
    .tagRdErrIrq(lines[3]), .dataRdErrIrq(lines[4]), .tagWrErrIrq(lines[5]),
    .dataWrErrIrq(lines[6]), .slvErrIrq(lines[7]), .decErrIrq(lines[8]),
    .combIrq(combIrq)
  );

  // Monitor: pops expected read results as the design returns them.
  always @(negedge clk) begin
    if (rstN && regRdValid) begin
      vecCnt++;
      if (expQ.size() == 0) begin
        badCnt++;
        $display("FAIL R11 unexpected read valid, actual %h expected none", regRdata);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdata !== e) begin
          badCnt++;
          $display("FAIL %s read actual %h expected %h", t, regRdata, e);
        end
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [11:0] a);
    case (a)
      12'h214: return {23'd0, expMask};
      12'h218: return {23'd0, expRaw & expMask};
      12'h21C: return {23'd0, expRaw};
      default: return 32'd0;
    endcase
  endfunction

  task automatic readReg(input logic [11:0] a, input string t);
    expQ.push_back(modelRead(a));
    tagQ.push_back(t);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0; regAddr = '0;
    @(negedge clk);
  endtask

  // Combined write/pulse cycle; model follows the requirements (set wins).
  task automatic cycle(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [8:0] p);
    logic [8:0] setM;
    setM = {1'b0, p[7] | p[8], p[6:0]};
    regWr = wr; regAddr = a; regWdata = d; src = p;
    @(negedge clk);
    regWr = 1'b0; regAddr = '0; regWdata = '0; src = '0;
    if (wr && a == 12'h214) expMask = d[8:0];
    if (wr && a == 12'h220) expRaw = expRaw & ~d[8:0];
    expRaw = expRaw | setM;
  endtask

  task automatic checkLines(input string t);
    logic [8:0] e;
    e = expRaw & expMask;
    vecCnt++;
    if (lines !== e) begin
      badCnt++;
      $display("FAIL %s lines actual %b expected %b", t, lines, e);
    end
    vecCnt++;
    if (combIrq !== (|e)) begin
      badCnt++;
      $display("FAIL %s combIrq actual %b expected %b", t, combIrq, |e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    badCnt++;
    $display("FAIL watchdog expired, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkLines("R1");
    vecCnt++;
    if (regRdValid !== 1'b0) begin
      badCnt++;
      $display("FAIL R1 regRdValid actual %b expected 0", regRdValid);
    end
    readReg(12'h21C, "R1 raw");
    readReg(12'h214, "R1 mask");
    readReg(12'h218, "R1 masked");

    // R2 each source alone, mask still zero so lines stay low (R6)
    for (int i = 0; i < 8; i++) begin
      cycle(1'b0, '0, '0, 9'(1 << i));
      checkLines("R6 masked off");
      readReg(12'h21C, "R2 raw after pulse");
    end
    repeat (5) @(negedge clk);
    readReg(12'h21C, "R2 sticky");

    // R8 mask read/write, upper bits read zero
    cycle(1'b1, 12'h214, 32'hFFFF_FFFF, '0);
    readReg(12'h214, "R8 mask all");
    checkLines("R7 all pending");

    // R4 partial clear
    cycle(1'b1, 12'h220, 32'h0000_0055, '0);
    readReg(12'h21C, "R4 partial clear");
    checkLines("R6 after clear");

    // R7 mask covers only cleared bits: combined low
    cycle(1'b1, 12'h214, 32'h0000_0005, '0);
    checkLines("R7 no overlap");
    readReg(12'h218, "R6 masked view");
    cycle(1'b1, 12'h214, 32'h0000_0022, '0);
    checkLines("R7 overlap");
    readReg(12'h218, "R6 masked view 2");

    // R3 decode folds into slave bit
    cycle(1'b1, 12'h220, 32'h0000_01FF, '0);
    cycle(1'b1, 12'h214, 32'h0000_01FF, '0);
    readReg(12'h21C, "R4 full clear");
    cycle(1'b0, '0, '0, 9'h100);
    readReg(12'h21C, "R3 decode as slave");
    checkLines("R3 decode line");

    // R5 set wins against clear of the same bit
    cycle(1'b1, 12'h220, 32'h0000_0088, 9'h008);
    readReg(12'h21C, "R5 set wins");
    checkLines("R5 lines");

    // R10 writes to status views ignored
    cycle(1'b1, 12'h218, 32'hFFFF_FFFF, '0);
    cycle(1'b1, 12'h21C, 32'hFFFF_FFFF, '0);
    cycle(1'b1, 12'h21C, 32'h0000_0000, '0);
    readReg(12'h21C, "R10 raw kept");
    readReg(12'h214, "R10 mask kept");

    // R9 clear and unmapped offsets read zero
    readReg(12'h220, "R9 clear reads zero");
    readReg(12'h300, "R9 unmapped");

    // R11 back-to-back reads, raw at 0x21C
    expQ.push_back(modelRead(12'h21C)); tagQ.push_back("R11 b2b first");
    regRd = 1'b1; regAddr = 12'h21C;
    @(negedge clk);
    expQ.push_back(modelRead(12'h214)); tagQ.push_back("R11 b2b second");
    regAddr = 12'h214;
    @(negedge clk);
    regRd = 1'b0; regAddr = '0;
    @(negedge clk);
    vecCnt++;
    if (regRdValid !== 1'b0) begin
      badCnt++;
      $display("FAIL R11 valid after idle actual %b expected 0", regRdValid);
    end

    repeat (3) @(negedge clk);
    vecCnt++;
    if (expQ.size() != 0) begin
      badCnt++;
      $display("FAIL R11 reads outstanding actual %0d expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  end
endmodule